// File: doc/BRIEF.md
# Per-Stage Memory Pipelined 16-Point FFT

This block computes a 16-point radix-2 decimation-in-frequency FFT on a stream of complex samples. Each of the four iterations owns a private sample memory and a private butterfly unit. A stage reads its own memory, runs eight butterflies in eight cycles and writes the results straight into the memory of the stage that follows. Handing the data on in this way frees the stage's memory at once, so a new frame can enter the first stage as soon as the first iteration of the previous frame has finished. The throughput therefore depends on the time one stage takes, not on the time of the whole transform.

The first stage works on the stream as it arrives. It stores the first eight samples of a frame. Each of the last eight samples is paired with its stored partner as soon as it arrives, so the first iteration ends on the same edge that accepts the final sample. After the last stage, a two-bank output memory holds one frame while the next frame is being written. Each frame is played out as 16 consecutive beats in natural frequency order, with a start marker on bin 0.

Samples are counted only on cycles where the input is valid, and every group of 16 valid samples forms one frame. Frames may follow each other with no idle cycle between them, and a frame may also contain idle cycles. The output width grows by four bits, which is enough for any input whose real and imaginary parts lie within half of the signed input range. Twiddle factors are signed values with 14 fractional bits, and each twiddle product is rounded to nearest.

Top module: `fft16_pipe`

## Requirements
- R1: While reset is low, and afterwards until the first frame result is ready, `out_valid` and `out_sop` stay at 0.
- R2: Each frame result is 16 `out_valid` beats on consecutive cycles. `out_sop` is 1 on the first beat and 0 on the other 15.
- R3: Beat k (k = 0 to 15) carries bin k of X[k] = sum over n of x[n]*exp(-j*2*pi*n*k/16). It is accurate to within 16 LSB on each of the real and imaginary parts, for inputs whose parts have magnitude of at most 2000.
- R4: The `out_sop` beat appears in the cycle after the 25th rising edge that follows the edge accepting the frame's 16th valid sample.
- R5: A new frame may start on the cycle right after the last sample of the previous frame. Frames sent back to back are each transformed exactly as if they had been sent alone.
- R6: Cycles with `in_valid` at 0 are ignored. A frame whose samples have idle cycles between them gives the same 16 outputs as the same frame sent without gaps.
- R7: If x[0] = A + jB and every other sample is 0, all 16 output bins equal A + jB exactly, with no rounding error.
- R8: The block gives exactly 16 output beats for each complete input frame and none otherwise. An incomplete trailing frame produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The sample on in_re/in_im is accepted on this edge |
| in_re | input | DW | Real part of the input sample, two's complement |
| in_im | input | DW | Imaginary part of the input sample, two's complement |
| out_valid | output | 1 | An output bin is present |
| out_sop | output | 1 | The present bin is bin 0 of a frame |
| out_re | output | DW+4 | Real part of the output bin |
| out_im | output | DW+4 | Imaginary part of the output bin |

## Verification
The bench sends frames back to back so that every stage memory is refilled right after it has drained. A stage that started before its memory was complete, or that handed off too late, would mix samples from two frames and produce wrong bins in the second frame. A frame with idle cycles between samples checks that only valid cycles are counted; miscounting would shift the frame boundary and corrupt that frame and every frame after it. Impulse frames must come out exact, and a single-tone frame must land on one bin, so a wrong twiddle index or a wrong bit-reversed readout order shows up as energy in the wrong bins. The bench also checks the start-marker cycle against the fixed latency and requires that a partial trailing frame produces no output, which catches readout-bank overlap and stray output beats.

// File: rtl/fft16_pkg.sv
// fft16_pkg: constants, twiddle table and butterfly addressing shared by
// all stages of the 16-point pipelined FFT.
// Assumes: N = 16, radix-2 decimation in frequency, twiddles in Q1.14.
package fft16_pkg;
    localparam int NPTS    = 16;
    localparam int LOG2N   = 4;
    localparam int HALF    = NPTS / 2;
    localparam int AW      = LOG2N;
    localparam int TW_W    = 16;
    localparam int TW_FRAC = 14;

    // Real part of exp(-j*2*pi*k/16), scaled by 2^14
    function automatic logic signed [TW_W-1:0] tw_re(input logic [2:0] k);
        case (k)
            3'd0: return 16'sd16384;
            3'd1: return 16'sd15137;
            3'd2: return 16'sd11585;
            3'd3: return 16'sd6270;
            3'd4: return 16'sd0;
            3'd5: return -16'sd6270;
            3'd6: return -16'sd11585;
            default: return -16'sd15137;
        endcase
    endfunction

    // Imaginary part of exp(-j*2*pi*k/16), scaled by 2^14
    function automatic logic signed [TW_W-1:0] tw_im(input logic [2:0] k);
        case (k)
            3'd0: return 16'sd0;
            3'd1: return -16'sd6270;
            3'd2: return -16'sd11585;
            3'd3: return -16'sd15137;
            3'd4: return -16'sd16384;
            3'd5: return -16'sd15137;
            3'd6: return -16'sd11585;
            default: return -16'sd6270;
        endcase
    endfunction

    // Lower address of butterfly c in stage s (span HALF >> s)
    function automatic logic [AW-1:0] bf_lo(input int s, input logic [2:0] c);
        logic [AW-1:0] c4, h, j, g;
        c4 = {1'b0, c};
        h  = AW'(HALF >> s);
        j  = c4 & (h - 1'b1);
        g  = c4 >> (LOG2N - 1 - s);
        return (g << (LOG2N - s)) | j;
    endfunction

    // Upper address of butterfly c in stage s
    function automatic logic [AW-1:0] bf_hi(input int s, input logic [2:0] c);
        return bf_lo(s, c) | AW'(HALF >> s);
    endfunction

    // Twiddle index of butterfly c in stage s
    function automatic logic [2:0] bf_tw(input int s, input logic [2:0] c);
        logic [AW-1:0] c4, h;
        c4 = {1'b0, c};
        h  = AW'(HALF >> s);
        return 3'((c4 & (h - 1'b1)) << s);
    endfunction

    // Reverse the four address bits
    function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] a);
        return {a[0], a[1], a[2], a[3]};
    endfunction
endpackage

// File: rtl/fft16_bfly.sv
// fft16_bfly: combinational radix-2 DIF butterfly.
// sum = a + b ; dif = round((a - b) * W^tw). Words are {re, im}, IW bits each.
// Assumes: the caller keeps magnitudes inside IW bits (no saturation here).
module fft16_bfly
    import fft16_pkg::*;
#(
    parameter int IW = 20
) (
    input  logic [2*IW-1:0] a,
    input  logic [2*IW-1:0] b,
    input  logic [2:0]      tw,
    output logic [2*IW-1:0] sum,
    output logic [2*IW-1:0] dif
);
    localparam int PW = IW + TW_W + 1;
    localparam logic signed [PW-1:0] RND = PW'(1) << (TW_FRAC - 1);

    logic signed [IW-1:0]   ar, ai, br, bi, dr, di;
    logic signed [TW_W-1:0] wr, wi;
    logic signed [PW-1:0]   drx, dix, wrx, wix, pr, pi;
    logic                   unused_bits;

    // Split operands and form the sum and difference
    always_comb begin
        ar = a[2*IW-1:IW];
        ai = a[IW-1:0];
        br = b[2*IW-1:IW];
        bi = b[IW-1:0];
        dr = ar - br;
        di = ai - bi;
        sum = {ar + br, ai + bi};
    end

    // Rotate the difference by the selected twiddle, rounding to nearest
    always_comb begin
        wr  = tw_re(tw);
        wi  = tw_im(tw);
        drx = {{(TW_W+1){dr[IW-1]}}, dr};
        dix = {{(TW_W+1){di[IW-1]}}, di};
        wrx = {{(IW+1){wr[TW_W-1]}}, wr};
        wix = {{(IW+1){wi[TW_W-1]}}, wi};
        pr  = drx * wrx - dix * wix + RND;
        pi  = drx * wix + dix * wrx + RND;
        dif = {pr[IW+TW_FRAC-1:TW_FRAC], pi[IW+TW_FRAC-1:TW_FRAC]};
    end

    assign unused_bits = ^{pr[TW_FRAC-1:0], pr[PW-1:IW+TW_FRAC],
                           pi[TW_FRAC-1:0], pi[PW-1:IW+TW_FRAC]};
endmodule

// File: rtl/fft16_entry.sv
// fft16_entry: first iteration, computed while the stream arrives.
// Samples 0..7 of a frame are stored. Sample 8+j is paired with stored
// sample j at once and the result is written into stage 1's memory.
// Assumes: frames are groups of 16 valid samples; no backpressure.
module fft16_entry
    import fft16_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = DW + LOG2N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_re,
    input  logic [DW-1:0]   in_im,
    output logic            nx_en,
    output logic [AW-1:0]   nx_a0,
    output logic [AW-1:0]   nx_a1,
    output logic [2*IW-1:0] nx_d0,
    output logic [2*IW-1:0] nx_d1,
    output logic            done
);
    logic [2*IW-1:0] mem [HALF];
    logic [AW-1:0]   cnt;
    logic [2*IW-1:0] smp;

    assign smp = {{(IW-DW){in_re[DW-1]}}, in_re, {(IW-DW){in_im[DW-1]}}, in_im};

    // Count valid samples within the frame
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (in_valid) cnt <= cnt + 1'b1;
    end

    // Keep the first half of the frame
    always_ff @(posedge clk) begin
        if (in_valid && !cnt[AW-1]) mem[cnt[AW-2:0]] <= smp;
    end

    fft16_bfly #(.IW(IW)) u_bfly (
        .a(mem[cnt[AW-2:0]]), .b(smp), .tw(bf_tw(0, cnt[AW-2:0])),
        .sum(nx_d0), .dif(nx_d1)
    );

    assign nx_en = in_valid && cnt[AW-1];
    assign nx_a0 = bf_lo(0, cnt[AW-2:0]);
    assign nx_a1 = bf_hi(0, cnt[AW-2:0]);
    assign done  = in_valid && (cnt == AW'(NPTS - 1));
endmodule

// File: rtl/fft16_stage.sv
// fft16_stage: iteration S (1..LOG2N-1) with its own memory and butterfly.
// The previous iteration writes this memory. On go, eight butterflies run
// in eight cycles and write the next memory directly. done marks the last one.
// Assumes: go never comes while the stage is busy (upstream pacing).
module fft16_stage
    import fft16_pkg::*;
#(
    parameter int IW = 20,
    parameter int S  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_a0,
    input  logic [AW-1:0]   wr_a1,
    input  logic [2*IW-1:0] wr_d0,
    input  logic [2*IW-1:0] wr_d1,
    input  logic            go,
    output logic            busy,
    output logic            nx_en,
    output logic [AW-1:0]   nx_a0,
    output logic [AW-1:0]   nx_a1,
    output logic [2*IW-1:0] nx_d0,
    output logic [2*IW-1:0] nx_d1,
    output logic            done
);
    logic [2*IW-1:0] mem [NPTS];
    logic [2:0]      cnt;

    // Accept the two results per cycle from the previous iteration
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_a0] <= wr_d0;
            mem[wr_a1] <= wr_d1;
        end
    end

    // Butterfly sequencer: eight cycles per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) busy <= 1'b0;
        end
    end

    assign nx_a0 = bf_lo(S, cnt);
    assign nx_a1 = bf_hi(S, cnt);

    fft16_bfly #(.IW(IW)) u_bfly (
        .a(mem[nx_a0]), .b(mem[nx_a1]), .tw(bf_tw(S, cnt)),
        .sum(nx_d0), .dif(nx_d1)
    );

    assign nx_en = busy;
    assign done  = busy && (cnt == 3'd7);
endmodule

// File: rtl/fft16_unload.sv
// fft16_unload: two-bank result memory. The last iteration writes one bank
// while the other is read out in bit-reversed address order, which gives
// bins in natural order, 16 beats per frame.
// Assumes: go (last iteration done) comes at most once per 16 cycles.
module fft16_unload
    import fft16_pkg::*;
#(
    parameter int IW = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_a0,
    input  logic [AW-1:0]   wr_a1,
    input  logic [2*IW-1:0] wr_d0,
    input  logic [2*IW-1:0] wr_d1,
    input  logic            go,
    output logic            out_valid,
    output logic            out_sop,
    output logic [IW-1:0]   out_re,
    output logic [IW-1:0]   out_im
);
    logic [2*IW-1:0] bank [2][NPTS];
    logic            wsel, rsel, rbusy;
    logic [AW-1:0]   rcnt;
    logic [2*IW-1:0] rword;

    // Results of the last iteration land in the write bank
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank[wsel][wr_a0] <= wr_d0;
            bank[wsel][wr_a1] <= wr_d1;
        end
    end

    // Swap banks on frame completion and run the 16-beat readout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel  <= 1'b0;
            rsel  <= 1'b0;
            rbusy <= 1'b0;
            rcnt  <= '0;
        end else if (go) begin
            wsel  <= ~wsel;
            rsel  <= wsel;
            rbusy <= 1'b1;
            rcnt  <= '0;
        end else if (rbusy) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == AW'(NPTS - 1)) rbusy <= 1'b0;
        end
    end

    assign rword = bank[rsel][bitrev(rcnt)];

    // Register the output beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= rbusy;
            out_sop   <= rbusy && (rcnt == '0);
            if (rbusy) begin
                out_re <= rword[2*IW-1:IW];
                out_im <= rword[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/fft16_pipe.sv
// fft16_pipe: top of the 16-point FFT with one memory and one butterfly per
// iteration. The stages are chained by write buses and done pulses.
// Assumes: input part magnitudes within half of the DW-bit range.
module fft16_pipe
    import fft16_pkg::*;
#(
    parameter int DW = 16,
    localparam int OW = DW + LOG2N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    output logic          out_sop,
    output logic [OW-1:0] out_re,
    output logic [OW-1:0] out_im
);
    // Bus k carries writes into the memory of iteration k (LOG2N = output bank)
    logic            wen [1:LOG2N];
    logic [AW-1:0]   wa0 [1:LOG2N];
    logic [AW-1:0]   wa1 [1:LOG2N];
    logic [2*OW-1:0] wd0 [1:LOG2N];
    logic [2*OW-1:0] wd1 [1:LOG2N];
    logic [LOG2N-1:0] sdone;
    logic [LOG2N-1:1] sbusy;

    fft16_entry #(.DW(DW), .IW(OW)) u_entry (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .nx_en(wen[1]), .nx_a0(wa0[1]), .nx_a1(wa1[1]), .nx_d0(wd0[1]), .nx_d1(wd1[1]),
        .done(sdone[0])
    );

    for (genvar s = 1; s < LOG2N; s++) begin : g_stage
        fft16_stage #(.IW(OW), .S(s)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wen[s]), .wr_a0(wa0[s]), .wr_a1(wa1[s]), .wr_d0(wd0[s]), .wr_d1(wd1[s]),
            .go(sdone[s-1]), .busy(sbusy[s]),
            .nx_en(wen[s+1]), .nx_a0(wa0[s+1]), .nx_a1(wa1[s+1]),
            .nx_d0(wd0[s+1]), .nx_d1(wd1[s+1]),
            .done(sdone[s])
        );
    end

    fft16_unload #(.IW(OW)) u_unload (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wen[LOG2N]), .wr_a0(wa0[LOG2N]), .wr_a1(wa1[LOG2N]),
        .wr_d0(wd0[LOG2N]), .wr_d1(wd1[LOG2N]),
        .go(sdone[LOG2N-1]),
        .out_valid(out_valid), .out_sop(out_sop), .out_re(out_re), .out_im(out_im)
    );
endmodule

// File: rtl/fft16_chk.sv
// fft16_chk: protocol and pacing properties of fft16_pipe, attached by bind.
// Assumes: fixed 4-iteration pipeline, so the latency window is a constant.
module fft16_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_done,
    input logic [2:0] stg_go,
    input logic [2:0] stg_busy,
    input logic       out_valid,
    input logic       out_sop
);
    logic [3:0] beat;

    // Position of the current output beat inside its frame
    always_ff @(posedge clk) begin
        if (!rst_n)         beat <= '0;
        else if (out_valid) beat <= beat + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_sop);

    p_sop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == (beat == 4'd0)));

    p_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(out_valid) && beat != 4'd0) |-> out_valid);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> $past(frame_done, 26));

    p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_go & stg_busy) == 3'b000);
endmodule

bind fft16_pipe fft16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_done(sdone[0]), .stg_go(sdone[2:0]),
    .stg_busy(sbusy), .out_valid(out_valid), .out_sop(out_sop)
);

// File: tb/fft16_pipe_bench.sv
// fft16_pipe_bench: behavioural reference (floating-point DFT, queues),
// compared against the design on every clock.
module fft16_pipe_bench;
    localparam int DW  = 16;
    localparam int OW  = DW + 4;
    localparam int LAT = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_re = '0;
    logic [DW-1:0] in_im = '0;
    logic          out_valid, out_sop;
    logic [OW-1:0] out_re, out_im;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int mbeat   = 0;
    bit done_flag = 0;

    int    q_re[$];
    int    q_im[$];
    int    q_tol[$];
    string q_tag[$];
    int    q_edge[$];

    int fr[16];
    int fi[16];

    fft16_pipe #(.DW(DW)) u_fft16_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sop(out_sop), .out_re(out_re), .out_im(out_im)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference DFT of the frame in fr/fi, pushed onto the expectation queues
    task automatic push_expect(input string tag, input int tol, input int edge_no);
        for (int k = 0; k < 16; k++) begin
            real sr, si, th;
            sr = 0.0;
            si = 0.0;
            for (int n = 0; n < 16; n++) begin
                th = 2.0 * 3.14159265358979 * n * k / 16.0;
                sr += fr[n] * $cos(th) + fi[n] * $sin(th);
                si += fi[n] * $cos(th) - fr[n] * $sin(th);
            end
            q_re.push_back(int'(sr));
            q_im.push_back(int'(si));
            q_tol.push_back(tol);
            q_tag.push_back(tag);
        end
        q_edge.push_back(edge_no);
    endtask

    // Drive one frame; gap > 0 inserts that many idle cycles after each sample
    task automatic send_frame(input string tag, input int tol, input int gap);
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = DW'(fr[n]);
            in_im = DW'(fi[n]);
            if (n == 15) push_expect(tag, tol, cyc + LAT);
            if (gap > 0 && n != 15) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_re = '1;
                    in_im = '1;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic int sx(input logic [OW-1:0] v);
        return int'($signed(v));
    endfunction

    // Compare every output beat against the head of the queue
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (out_valid) begin
                if (q_re.size() == 0) begin
                    check(0, "R8", "beat with no pending frame", 1, 0);
                end else begin
                    int er, ei, tl, dr, di;
                    string tg;
                    er = q_re.pop_front();
                    ei = q_im.pop_front();
                    tl = q_tol.pop_front();
                    tg = q_tag.pop_front();
                    dr = sx(out_re) - er;
                    di = sx(out_im) - ei;
                    check(dr <= tl && dr >= -tl, tg, $sformatf("bin %0d re", mbeat), sx(out_re), er);
                    check(di <= tl && di >= -tl, tg, $sformatf("bin %0d im", mbeat), sx(out_im), ei);
                    if (mbeat == 0) begin
                        int ee;
                        ee = q_edge.pop_front();
                        check(out_sop == 1'b1, "R2", "sop on bin 0", int'(out_sop), 1);
                        check(cyc == ee, "R4", "sop cycle", cyc, ee);
                    end else begin
                        check(out_sop == 1'b0, "R2", "sop off mid-frame", int'(out_sop), 0);
                    end
                end
                mbeat = (mbeat + 1) % 16;
            end else if (mbeat != 0) begin
                check(0, "R2", "gap inside output burst", 0, 1);
                mbeat = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0 && out_sop == 1'b0, "R1", "outputs during reset",
              int'(out_valid), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        end

        // R7: impulse at n=0 gives a flat spectrum, exactly
        foreach (fr[n]) begin fr[n] = 0; fi[n] = 0; end
        fr[0] = 1500; fi[0] = -700;
        send_frame("R7", 0, 0);
        idle(40);

        // R3: impulse at n=1 (pure rotation through every twiddle)
        foreach (fr[n]) begin fr[n] = 0; fi[n] = 0; end
        fr[1] = 2000;
        send_frame("R3", 16, 0);
        // R3: constant input, energy in bin 0 only
        foreach (fr[n]) begin fr[n] = 900; fi[n] = -300; end
        send_frame("R3", 16, 0);
        // R3: alternating sign, energy in bin 8 only
        foreach (fr[n]) begin fr[n] = (n % 2) ? -1200 : 1200; fi[n] = 0; end
        send_frame("R3", 16, 0);
        // R3: complex tone on bin 3
        foreach (fr[n]) begin
            fr[n] = int'(1000.0 * $cos(2.0 * 3.14159265358979 * 3 * n / 16.0));
            fi[n] = int'(1000.0 * $sin(2.0 * 3.14159265358979 * 3 * n / 16.0));
        end
        send_frame("R3", 16, 0);
        idle(3);

        // R5: back-to-back random frames
        for (int f = 0; f < 6; f++) begin
            foreach (fr[n]) begin
                fr[n] = int'($urandom_range(4000)) - 2000;
                fi[n] = int'($urandom_range(4000)) - 2000;
            end
            send_frame("R5", 16, 0);
        end
        // R6: same kind of frame with idle cycles between samples
        foreach (fr[n]) begin
            fr[n] = int'($urandom_range(4000)) - 2000;
            fi[n] = int'($urandom_range(4000)) - 2000;
        end
        send_frame("R6", 16, 2);
        // R6/R7: another exact impulse directly after the gapped frame
        foreach (fr[n]) begin fr[n] = 0; fi[n] = 0; end
        fr[0] = -2000; fi[0] = 1999;
        send_frame("R6", 0, 1);

        // R8: a partial frame of 7 samples must produce nothing
        for (int n = 0; n < 7; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = DW'(n * 100);
            in_im = '0;
        end
        idle(80);
        check(q_re.size() == 0, "R8", "pending bins after drain", q_re.size(), 0);
        check(out_valid == 1'b0, "R8", "idle after partial frame", int'(out_valid), 0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule